// File: doc/BRIEF.md
# Auto-Baud Boot Serial Handshake

This block is the serial front end used while a chip boots from a host. After reset it holds its transmit line high and, after a short settling wait, watches the receive line. The host repeatedly sends zero bytes. In an 8N1 frame a zero byte keeps the line low for nine bit times: the start bit plus eight zero data bits. The block counts the cycles of each low run. It takes a run as valid once several runs in a row agree. It then divides the count by nine, rounding to the nearest cycle, and loads the result as its bit-period divisor.

With the divisor loaded, the block sends one zero byte back as its acknowledge. It then expects one 0x55 byte from the host, received at the learned rate. A correct byte ends the handshake with `done`. A wrong byte, a bad stop bit, a missing edge or a low run that is too short ends it with `err`. Both end states are terminal. Only a reset or a watchdog overflow starts the sequence again. In both end states the receiver and transmitter are idle, `txd` stays high and the learned divisor stays on `divisor` for later transfers.

The line interface is plain serial, so there is no valid/ready stream at the block's edge and no back-pressure applies. Every other pin is a plain level.

Top module: `abd_boot_link`

## Requirements
- R1: During reset, and in the cycle after a one-cycle `wdt_ovf` pulse, `txd`=1, `done`=0, `err`=0, `div_valid`=0 and `divisor`=0. A watchdog pulse restarts the whole sequence in the same way a reset does.
- R2: For the first STARTUP_CYC (100) cycles after reset release, activity on `rxd` is ignored. A low pulse in that window causes neither an error nor a measurement.
- R3: A measurement is the number of cycles `rxd` stays low after a falling edge. NUM_FRAMES (3) consecutive measurements must each lie within the tolerance of the first one in the set, defined as 144·|m−first| ≤ first (1/16 of a bit). A measurement outside the tolerance starts a new set, with that measurement as its first.
- R4: On acceptance, `divisor` = (first + 4) / 9 using integer division, and `div_valid` rises.
- R5: The acknowledge is exactly one byte 0x00 on `txd`, sent 8N1 with LSB first and each bit lasting `divisor` cycles. `txd` is therefore low for 9·`divisor` consecutive cycles and then high.
- R6: After the acknowledge, a byte 0x55 with a high stop bit, received at the learned rate, sets `done`=1. `done` stays set until reset or watchdog.
- R7: Any other byte value, or a low stop bit, sets `err`=1 and leaves `done`=0. `err` stays set until reset or watchdog.
- R8: If no falling edge on `rxd` arrives within `edge_timeout` cycles, either while measuring or while waiting for the confirmation byte, `err` becomes 1.
- R9: A low run shorter than MIN_LOW (36) cycles sets `err`=1.
- R10: Once `done` or `err` is set, `txd` stays high, `rxd` is ignored and `divisor` holds its value.
- R11: `done` and `err` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdt_ovf | input | 1 | Watchdog overflow; acts as a synchronous reset of the sequence |
| rxd | input | 1 | Serial receive line, idle high |
| edge_timeout | input | CNT_W (20) | Cycles allowed while waiting for a falling edge |
| txd | output | 1 | Serial transmit line, idle high |
| divisor | output | DIV_W (16) | Learned bit period in clock cycles |
| div_valid | output | 1 | `divisor` holds a learned value |
| done | output | 1 | Handshake completed |
| err | output | 1 | Handshake failed |

## Verification
The assertions assume that `rxd` is high when reset ends and that `wdt_ovf` is a synchronous pulse. They also assume that the host stops sending zero frames once the final measured frame has ended, so no zero frame overlaps the acknowledge or the confirmation byte. The bench drives every bit with a whole number of cycles and keeps the line high after the last zero frame. It starts the confirmation byte only after the acknowledge's stop bit has finished, and it sends that byte at exactly the learned period. This keeps all stimulus inside those assumptions, while separate cases still break the tolerance, minimum-length, timeout and stop-bit rules on purpose.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [2:0] {
    ST_START,
    ST_MEAS,
    ST_ACK,
    ST_CONF,
    ST_DONE,
    ST_ERR
  } boot_st_e;

  localparam logic [7:0] ACK_BYTE  = 8'h00;
  localparam logic [7:0] CONF_BYTE = 8'h55;
endpackage

// File: rtl/abd_low_meter.sv
module abd_low_meter #(
  parameter int CNT_W      = 20,
  parameter int NUM_FRAMES = 3,
  parameter int MIN_LOW    = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             rx,
  input  logic [CNT_W-1:0] timeout,
  output logic             lock,
  output logic             fail,
  output logic [CNT_W-1:0] ref_cnt
);
  localparam int AG_W   = $clog2(NUM_FRAMES + 1);
  localparam int PROD_W = CNT_W + 8;

  logic             rx_q;
  logic             in_low;
  logic [CNT_W-1:0] low_cnt;
  logic [CNT_W-1:0] idle_cnt;
  logic [AG_W-1:0]  agree;
  logic [CNT_W-1:0] diff;
  logic [PROD_W-1:0] scaled;
  logic             close;

  // tolerance test without a divider: 144*|d| <= first
  always_comb begin
    diff   = (low_cnt > ref_cnt) ? (low_cnt - ref_cnt) : (ref_cnt - low_cnt);
    scaled = PROD_W'(diff) * PROD_W'(144);
    close  = scaled <= PROD_W'(ref_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q     <= 1'b1;
      in_low   <= 1'b0;
      low_cnt  <= '0;
      idle_cnt <= '0;
      agree    <= '0;
      ref_cnt  <= '0;
      lock     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      rx_q <= rx;
      lock <= 1'b0;
      fail <= 1'b0;
      if (clr || !en) begin
        in_low   <= 1'b0;
        idle_cnt <= '0;
        agree    <= '0;
        if (clr) ref_cnt <= '0;
      end else if (!in_low) begin
        if (rx_q && !rx) begin
          in_low   <= 1'b1;
          low_cnt  <= CNT_W'(1);
          idle_cnt <= '0;
        end else if (idle_cnt >= timeout) begin
          fail <= 1'b1;
        end else begin
          idle_cnt <= idle_cnt + CNT_W'(1);
        end
      end else if (!rx) begin
        if (low_cnt != '1) low_cnt <= low_cnt + CNT_W'(1);
      end else begin
        in_low <= 1'b0;
        if (low_cnt < CNT_W'(MIN_LOW)) begin
          fail <= 1'b1;
        end else if (agree != '0 && close) begin
          agree <= agree + AG_W'(1);
          if (agree == AG_W'(NUM_FRAMES - 1)) lock <= 1'b1;
        end else begin
          ref_cnt <= low_cnt;
          agree   <= AG_W'(1);
        end
      end
    end
  end

  AST_LOCK_ABOVE_MIN: assert property (@(posedge clk) disable iff (!rst_n || clr)
    lock |-> (ref_cnt >= CNT_W'(MIN_LOW))); // R9
  AST_LOCK_NOT_FAIL: assert property (@(posedge clk) disable iff (!rst_n || clr)
    lock |-> !fail); // R11
endmodule

// File: rtl/abd_uart_rx.sv
module abd_uart_rx #(
  parameter int DIV_W = 16,
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             rx,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] timeout,
  output logic             byte_vld,
  output logic [7:0]       byte_data,
  output logic             stop_ok,
  output logic             fail
);
  logic             rx_q;
  logic             active;
  logic [DIV_W-1:0] tcnt;
  logic [3:0]       bit_idx;
  logic [CNT_W-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q      <= 1'b1;
      active    <= 1'b0;
      tcnt      <= '0;
      bit_idx   <= '0;
      idle_cnt  <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      stop_ok   <= 1'b0;
      fail      <= 1'b0;
    end else begin
      rx_q     <= rx;
      byte_vld <= 1'b0;
      fail     <= 1'b0;
      if (clr || !en) begin
        active   <= 1'b0;
        idle_cnt <= '0;
      end else if (!active) begin
        if (rx_q && !rx) begin
          active   <= 1'b1;
          tcnt     <= div >> 1;   // first sample lands mid start bit
          bit_idx  <= '0;
          idle_cnt <= '0;
        end else if (idle_cnt >= timeout) begin
          fail <= 1'b1;
        end else begin
          idle_cnt <= idle_cnt + CNT_W'(1);
        end
      end else if (tcnt >= div - DIV_W'(1)) begin
        tcnt <= '0;
        if (bit_idx == 4'd0) begin
          if (rx) active <= 1'b0;   // glitch, not a start bit
          else    bit_idx <= 4'd1;
        end else if (bit_idx == 4'd9) begin
          active   <= 1'b0;
          byte_vld <= 1'b1;
          stop_ok  <= rx;
        end else begin
          byte_data <= {rx, byte_data[7:1]};
          bit_idx   <= bit_idx + 4'd1;
        end
      end else begin
        tcnt <= tcnt + DIV_W'(1);
      end
    end
  end

  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n || clr)
    byte_vld |=> !byte_vld); // R6
endmodule

// File: rtl/abd_uart_tx.sv
module abd_uart_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [7:0]       data,
  input  logic [DIV_W-1:0] div,
  output logic             txd,
  output logic             busy
);
  logic [9:0]       sh;
  logic [3:0]       bit_idx;
  logic [DIV_W-1:0] tcnt;

  assign txd = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '1;
      bit_idx <= '0;
      tcnt    <= '0;
      busy    <= 1'b0;
    end else if (clr) begin
      sh   <= '1;
      busy <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        sh      <= {1'b1, data, 1'b0};
        bit_idx <= '0;
        tcnt    <= '0;
        busy    <= 1'b1;
      end
    end else if (tcnt >= div - DIV_W'(1)) begin
      tcnt <= '0;
      sh   <= {1'b1, sh[9:1]};
      if (bit_idx == 4'd9) busy <= 1'b0;
      else                 bit_idx <= bit_idx + 4'd1;
    end else begin
      tcnt <= tcnt + DIV_W'(1);
    end
  end

  AST_TX_START_BIT: assert property (@(posedge clk) disable iff (!rst_n || clr)
    $rose(busy) |-> !txd); // R5
endmodule

// File: rtl/abd_boot_link.sv
module abd_boot_link
  import abd_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int DIV_W       = 16,
  parameter int NUM_FRAMES  = 3,
  parameter int MIN_LOW     = 36,
  parameter int STARTUP_CYC = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdt_ovf,
  input  logic             rxd,
  input  logic [CNT_W-1:0] edge_timeout,
  output logic             txd,
  output logic [DIV_W-1:0] divisor,
  output logic             div_valid,
  output logic             done,
  output logic             err
);
  localparam int SU_W = $clog2(STARTUP_CYC + 1);

  boot_st_e         st;
  logic [SU_W-1:0]  su_cnt;
  logic [DIV_W-1:0] div_q;
  logic             rx_s1, rx_s2;
  logic             m_lock, m_fail;
  logic [CNT_W-1:0] m_ref;
  logic             r_vld, r_stop, r_fail;
  logic [7:0]       r_data;
  logic             tx_busy, tx_start;
  logic [CNT_W:0]   rnd_sum, quo;
  logic [DIV_W-1:0] div_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
    end
  end

  // nearest-cycle bit period: (low + 4) / 9
  always_comb begin
    rnd_sum  = {1'b0, m_ref} + (CNT_W+1)'(4);
    quo      = rnd_sum / (CNT_W+1)'(9);
    div_next = DIV_W'(quo);
  end

  assign tx_start = (st == ST_MEAS) && m_lock && !m_fail;

  abd_low_meter #(.CNT_W(CNT_W), .NUM_FRAMES(NUM_FRAMES), .MIN_LOW(MIN_LOW)) i_meter (
    .clk(clk), .rst_n(rst_n), .clr(wdt_ovf), .en(st == ST_MEAS), .rx(rx_s2),
    .timeout(edge_timeout), .lock(m_lock), .fail(m_fail), .ref_cnt(m_ref)
  );

  abd_uart_tx #(.DIV_W(DIV_W)) i_tx (
    .clk(clk), .rst_n(rst_n), .clr(wdt_ovf), .start(tx_start), .data(ACK_BYTE),
    .div(div_q), .txd(txd), .busy(tx_busy)
  );

  abd_uart_rx #(.DIV_W(DIV_W), .CNT_W(CNT_W)) i_rx (
    .clk(clk), .rst_n(rst_n), .clr(wdt_ovf), .en(st == ST_CONF), .rx(rx_s2),
    .div(div_q), .timeout(edge_timeout), .byte_vld(r_vld), .byte_data(r_data),
    .stop_ok(r_stop), .fail(r_fail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_START;
      su_cnt    <= '0;
      div_q     <= '0;
      div_valid <= 1'b0;
    end else if (wdt_ovf) begin
      st        <= ST_START;
      su_cnt    <= '0;
      div_q     <= '0;
      div_valid <= 1'b0;
    end else begin
      unique case (st)
        ST_START: begin
          if (su_cnt == SU_W'(STARTUP_CYC - 1)) st <= ST_MEAS;
          else su_cnt <= su_cnt + SU_W'(1);
        end
        ST_MEAS: begin
          if (m_fail) begin
            st <= ST_ERR;
          end else if (m_lock) begin
            div_q     <= div_next;
            div_valid <= 1'b1;
            st        <= ST_ACK;
          end
        end
        ST_ACK: if (!tx_busy) st <= ST_CONF;
        ST_CONF: begin
          if (r_fail) st <= ST_ERR;
          else if (r_vld) st <= (r_data == CONF_BYTE && r_stop) ? ST_DONE : ST_ERR;
        end
        default: ;
      endcase
    end
  end

  assign divisor = div_q;
  assign done    = (st == ST_DONE);
  assign err     = (st == ST_ERR);

  AST_DONE_NEEDS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> div_valid); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n || wdt_ovf)
    done |=> done); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n || wdt_ovf)
    err |=> err); // R7
  AST_TXD_IDLE: assert property (@(posedge clk) disable iff (!rst_n || wdt_ovf)
    (st != ST_ACK) |-> txd); // R10
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n || wdt_ovf)
    div_valid |=> (div_valid && $stable(divisor))); // R10
  AST_QUIET_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START) |-> (!div_valid && !m_lock)); // R2
endmodule

// File: tb/test_abd_boot_link.sv
module test_abd_boot_link;
  localparam int CNT_W = 20;
  localparam int DIV_W = 16;
  localparam int NV    = 5;
  // fields: frames, low0..low3, confirm byte, expected divisor, expected done
  localparam int VEC [NV][8] = '{
    '{3, 184, 184, 184,   0, 8'h55, 20, 1},
    '{3, 185, 184, 185,   0, 8'h55, 21, 1},
    '{4,  90,  91,  91,  91, 8'h55, 10, 1},
    '{3, 117, 117, 117,   0, 8'hAA, 13, 0},
    '{3, 360, 362, 358,   0, 8'h55, 40, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdt_ovf = 1'b0;
  logic rxd = 1'b1;
  logic [CNT_W-1:0] edge_timeout = CNT_W'(100000);
  logic txd, div_valid, done, err;
  logic [DIV_W-1:0] divisor;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 0;
  bit  both_seen = 0;

  always #5 clk = ~clk;

  abd_boot_link i_abd_boot_link (
    .clk(clk), .rst_n(rst_n), .wdt_ovf(wdt_ovf), .rxd(rxd), .edge_timeout(edge_timeout),
    .txd(txd), .divisor(divisor), .div_valid(div_valid), .done(done), .err(err)
  );

  always @(negedge clk) if (rst_n && done && err) both_seen = 1;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rxd = 1'b1; wdt_ovf = 1'b0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic low_run(input int n, input int hi);
    rxd = 1'b0; cyc(n); rxd = 1'b1; cyc(hi);
  endtask

  task automatic get_ack(output int lowlen);
    lowlen = 0;
    for (int i = 0; i < 600 && txd; i++) cyc(1);
    while (!txd && lowlen < 100000) begin
      lowlen++;
      cyc(1);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int bp, input bit stop);
    rxd = 1'b0; cyc(bp);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i]; cyc(bp);
    end
    rxd = stop; cyc(bp);
    rxd = 1'b1;
  endtask

  task automatic wait_end(input int lim);
    for (int i = 0; i < lim && !done && !err; i++) cyc(1);
  endtask

  task automatic zero_frames(input int n, input int len);
    for (int f = 0; f < n; f++) low_run(len, (f == n - 1) ? 0 : len / 9 + 2);
  endtask

  initial begin
    int ack;
    int lows;
    cyc(2);
    // reset state
    check("R1 txd in reset", txd, 1);
    check("R1 done in reset", done, 0);
    check("R1 err in reset", err, 0);
    check("R1 div_valid in reset", div_valid, 0);
    check("R1 divisor in reset", divisor, 0);

    // vector walk; entry 2 exercises the R3 restart on an out-of-tolerance frame
    for (int v = 0; v < NV; v++) begin
      do_reset();
      cyc(110);
      for (int f = 0; f < VEC[v][0]; f++)
        low_run(VEC[v][1 + f], (f == VEC[v][0] - 1) ? 0 : VEC[v][1 + f] / 9 + 2);
      get_ack(ack);
      check("R5 ack low length", ack, 9 * VEC[v][6]);
      check("R3 R4 divisor", divisor, VEC[v][6]);
      check("R4 div_valid", div_valid, 1);
      cyc(2 * VEC[v][6]);
      send_byte(8'(VEC[v][5]), VEC[v][6], 1'b1);
      wait_end(400);
      check("R6 done", done, VEC[v][7]);
      check("R7 err", err, 1 - VEC[v][7]);
    end

    // R2: low pulse during startup wait is ignored
    do_reset();
    cyc(5);
    low_run(20, 90);
    zero_frames(3, 184);
    get_ack(ack);
    check("R2 ack after startup pulse", ack, 180);
    check("R2 no error from startup pulse", err, 0);
    cyc(40);
    send_byte(8'h55, 20, 1'b1);
    wait_end(400);
    check("R2 handshake completes", done, 1);

    // R10: activity after done changes nothing
    lows = 0;
    fork
      begin
        zero_frames(3, 184);
        cyc(30);
        send_byte(8'h00, 20, 1'b1);
        send_byte(8'h55, 20, 1'b1);
      end
      begin
        for (int i = 0; i < 2000; i++) begin
          @(negedge clk);
          if (!txd) lows++;
        end
      end
    join
    check("R10 txd held high", lows, 0);
    check("R10 divisor held", divisor, 20);
    check("R10 done held", done, 1);
    check("R10 err stays low", err, 0);

    // R1: watchdog pulse acts as reset and restarts the sequence
    wdt_ovf = 1'b1; cyc(1); wdt_ovf = 1'b0;
    check("R1 wdt clears done", done, 0);
    check("R1 wdt clears divisor", divisor, 0);
    check("R1 wdt clears div_valid", div_valid, 0);
    check("R1 wdt txd high", txd, 1);
    cyc(110);
    zero_frames(3, 117);
    get_ack(ack);
    check("R1 restart ack length", ack, 117);
    cyc(26);
    send_byte(8'h55, 13, 1'b1);
    wait_end(400);
    check("R1 restart done", done, 1);

    // R8: no falling edge while measuring
    edge_timeout = CNT_W'(500);
    do_reset();
    cyc(550);
    check("R8 no timeout yet", err, 0);
    cyc(150);
    check("R8 measure timeout", err, 1);

    // R8: no confirmation byte
    edge_timeout = CNT_W'(2000);
    do_reset();
    cyc(110);
    zero_frames(3, 184);
    get_ack(ack);
    check("R8 ack before confirm timeout", ack, 180);
    cyc(100);
    check("R8 still waiting", err, 0);
    cyc(2500);
    check("R8 confirm timeout", err, 1);
    edge_timeout = CNT_W'(100000);

    // R9: too short a low run
    do_reset();
    cyc(110);
    low_run(20, 10);
    check("R9 short low error", err, 1);
    check("R9 no done", done, 0);

    // R7: low stop bit on the confirmation byte
    do_reset();
    cyc(110);
    zero_frames(3, 184);
    get_ack(ack);
    cyc(40);
    send_byte(8'h55, 20, 1'b0);
    wait_end(400);
    check("R7 bad stop error", err, 1);
    check("R7 bad stop no done", done, 0);

    check("R11 done and err never together", both_seen, 0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule